// File: doc/BRIEF.md
# Cascaded Interrupt Control Unit

This block collects the level interrupt requests of up to 26 on-chip peripherals and 32 general-purpose I/O pins and merges them into one interrupt request towards the processor. It works in two tiers. The I/O pins are captured in a 32-bit pin status word with its own 32-bit enable mask. Whenever any enabled pin is pending, one dedicated peripheral line of the first tier is driven by that combined result instead of by its external input. The first tier holds two 16-bit peripheral status words. Peripheral lines 0 to 15 land in the low word and lines 16 to 25 in the bottom ten bits of the high word. Each word has its own 16-bit enable mask. The processor request is the OR of both masked words.

Software reaches the block through a 16-bit register port. Reads are combinational from the address, and writes take effect at the clock edge. Status bits are level-sensitive: each one follows its source every clock. A software write of 1 clears a bit for one cycle, and the bit sets again on the next cycle if the source is still high. Mask registers are plain read/write storage. All state starts at zero after reset.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: While reset is low and one clock after it, all status and mask registers read zero and `cpu_irq` is low.
- R2: Peripheral line i (0..15, except the cascade line 9) appears at bit i of the low status word (offset 0x080) one clock after it is sampled. Line i (16..25) appears at bit i-16 of the high status word (offset 0x0A0). Bits 10..15 of the high word always read zero.
- R3: A status bit clears one clock after its source is sampled low.
- R4: `cpu_irq` is high exactly when (low status AND low mask) OR (high status AND high mask) is nonzero, combinationally from the registers.
- R5: A write to a mask register (low mask 0x08C, high mask 0x0A6) replaces all 16 bits, and a read returns the stored value. Masks change only when written.
- R6: A write to a peripheral status word clears, at that clock, every bit where the write data is 1. A bit whose source is still high reads 1 again one clock later.
- R7: Pin j of the I/O inputs appears in the pin status word one clock after it is sampled. Bits 0..15 read at 0x088 and 0x108, and bits 16..31 read at 0x08A and 0x10A. A write of 1s to any of these four offsets clears the matching bits, with the same one-cycle re-set as in R6.
- R8: The pin mask is read/write with full replacement: bits 0..15 at 0x094 and bits 16..31 at 0x096.
- R9: Bit 9 of the low status word is sampled from the cascade request, which is high while (pin status AND pin mask) is nonzero. The external peripheral input 9 is ignored.
- R10: Reads of any other offset return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_irq | input | 26 | Peripheral request levels; bit 9 is replaced by the cascade |
| gpio_irq | input | 32 | I/O pin request levels |
| wr_en | input | 1 | Register write strobe for this clock |
| addr | input | 9 | Register byte offset |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| cpu_irq | output | 1 | Combined processor interrupt request |

## Verification
The properties assume that every request input is already synchronous to `clk` and holds a defined level at each rising edge. They also assume that `addr`, `wr_en` and `wr_data` are settled before the edge, because each property compares a register with the sampled input one cycle earlier. The bench changes all inputs only on the falling edge or shortly after the rising edge, and holds them at defined values from time zero. The random phase draws source levels, offsets (unused ones included) and data from a seeded generator, so status, mask and clear writes interleave freely while staying within these assumptions.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int N_PERIPH  = 26,
  parameter int N_GPIO    = 32,
  parameter int GPIO_LINE = 9,
  parameter int AW        = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PERIPH-1:0] periph_irq,
  input  logic [N_GPIO-1:0]   gpio_irq,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [15:0]         wr_data,
  output logic [15:0]         rd_data,
  output logic                cpu_irq
);
  localparam logic [AW-1:0] A_STAT_LO  = AW'('h080);
  localparam logic [AW-1:0] A_PIN_LO   = AW'('h088);
  localparam logic [AW-1:0] A_PIN_HI   = AW'('h08A);
  localparam logic [AW-1:0] A_MASK_LO  = AW'('h08C);
  localparam logic [AW-1:0] A_PMSK_LO  = AW'('h094);
  localparam logic [AW-1:0] A_PMSK_HI  = AW'('h096);
  localparam logic [AW-1:0] A_STAT_HI  = AW'('h0A0);
  localparam logic [AW-1:0] A_MASK_HI  = AW'('h0A6);
  localparam logic [AW-1:0] A_PIN_LO2  = AW'('h108);
  localparam logic [AW-1:0] A_PIN_HI2  = AW'('h10A);

  logic [15:0] stat_lo_q, stat_hi_q, mask_lo_q, mask_hi_q;
  logic [31:0] pin_stat_q, pin_mask_q;
  logic [15:0] src_lo, src_hi;
  logic [31:0] pin_src;
  logic        cascade_req;

  logic hit_stat_lo, hit_stat_hi, hit_mask_lo, hit_mask_hi;
  logic hit_pin_lo, hit_pin_hi, hit_pmsk_lo, hit_pmsk_hi;

  assign hit_stat_lo = wr_en && addr == A_STAT_LO;
  assign hit_stat_hi = wr_en && addr == A_STAT_HI;
  assign hit_mask_lo = wr_en && addr == A_MASK_LO;
  assign hit_mask_hi = wr_en && addr == A_MASK_HI;
  assign hit_pin_lo  = wr_en && (addr == A_PIN_LO || addr == A_PIN_LO2);
  assign hit_pin_hi  = wr_en && (addr == A_PIN_HI || addr == A_PIN_HI2);
  assign hit_pmsk_lo = wr_en && addr == A_PMSK_LO;
  assign hit_pmsk_hi = wr_en && addr == A_PMSK_HI;

  assign pin_src     = 32'(gpio_irq);
  assign cascade_req = |(pin_stat_q & pin_mask_q);
  assign src_hi      = 16'(periph_irq[N_PERIPH-1:16]);

  always_comb begin
    src_lo = periph_irq[15:0];
    src_lo[GPIO_LINE] = cascade_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_lo_q  <= '0;
      stat_hi_q  <= '0;
      mask_lo_q  <= '0;
      mask_hi_q  <= '0;
      pin_stat_q <= '0;
      pin_mask_q <= '0;
    end else begin
      stat_lo_q  <= src_lo & ~(hit_stat_lo ? wr_data : 16'h0);
      stat_hi_q  <= src_hi & ~(hit_stat_hi ? wr_data : 16'h0);
      pin_stat_q <= pin_src & ~{hit_pin_hi ? wr_data : 16'h0,
                                hit_pin_lo ? wr_data : 16'h0};
      if (hit_mask_lo) mask_lo_q <= wr_data;
      if (hit_mask_hi) mask_hi_q <= wr_data;
      if (hit_pmsk_lo) pin_mask_q[15:0]  <= wr_data;
      if (hit_pmsk_hi) pin_mask_q[31:16] <= wr_data;
    end
  end

  assign cpu_irq = |(stat_lo_q & mask_lo_q) | |(stat_hi_q & mask_hi_q);

  always_comb begin
    unique case (addr)
      A_STAT_LO:           rd_data = stat_lo_q;
      A_STAT_HI:           rd_data = stat_hi_q;
      A_MASK_LO:           rd_data = mask_lo_q;
      A_MASK_HI:           rd_data = mask_hi_q;
      A_PIN_LO, A_PIN_LO2: rd_data = pin_stat_q[15:0];
      A_PIN_HI, A_PIN_HI2: rd_data = pin_stat_q[31:16];
      A_PMSK_LO:           rd_data = pin_mask_q[15:0];
      A_PMSK_HI:           rd_data = pin_mask_q[31:16];
      default:             rd_data = 16'h0;
    endcase
  end
endmodule

// File: rtl/cascade_irq_ctrl_chk.sv
module cascade_irq_ctrl_chk #(
  parameter int N_PERIPH  = 26,
  parameter int GPIO_LINE = 9,
  parameter int AW        = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_PERIPH-1:0] periph_irq,
  input logic                wr_en,
  input logic [AW-1:0]       addr,
  input logic [15:0]         wr_data,
  input logic [15:0]         rd_data,
  input logic                cpu_irq,
  input logic [15:0]         s_lo,
  input logic [15:0]         s_hi,
  input logic [15:0]         m_lo,
  input logic [15:0]         m_hi,
  input logic [31:0]         p_stat,
  input logic [31:0]         p_mask
);
  localparam logic [15:0] KEEP = ~(16'h1 << GPIO_LINE);
  logic wr_slo, wr_shi, wr_mlo;
  assign wr_slo = wr_en && addr == AW'('h080);
  assign wr_shi = wr_en && addr == AW'('h0A0);
  assign wr_mlo = wr_en && addr == AW'('h08C);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (s_lo == 0 && s_hi == 0 && m_lo == 0 && m_hi == 0 &&
                p_stat == 0 && p_mask == 0 && !cpu_irq));

  p_follow_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_slo |=> ((s_lo ^ $past(periph_irq[15:0])) & KEEP) == 16'h0);

  p_follow_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_shi |=> s_hi == 16'($past(periph_irq[N_PERIPH-1:16])));

  p_irq_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_lo & m_lo) != 0 || (s_hi & m_hi) != 0) |-> cpu_irq);

  p_irq_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_lo == 0 && m_hi == 0) |-> !cpu_irq);

  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mlo |=> m_lo == $past(wr_data));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mlo |=> $stable(m_lo));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slo |=> (s_lo & $past(wr_data)) == 16'h0);

  p_cascade_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_slo |=> s_lo[GPIO_LINE] == $past(|(p_stat & p_mask)));

  p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    addr == AW'('h084) |-> rd_data == 16'h0);
endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk #(
  .N_PERIPH(N_PERIPH), .GPIO_LINE(GPIO_LINE), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .periph_irq(periph_irq), .wr_en(wr_en),
  .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .cpu_irq(cpu_irq),
  .s_lo(stat_lo_q), .s_hi(stat_hi_q), .m_lo(mask_lo_q), .m_hi(mask_hi_q),
  .p_stat(pin_stat_q), .p_mask(pin_mask_q)
);

// File: tb/test_cascade_irq_ctrl.sv
`timescale 1ns/1ps
module test_cascade_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] periph_irq = '0;
  logic [31:0] gpio_irq = '0;
  logic        wr_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        cpu_irq;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cascade_irq_ctrl i_cascade_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .periph_irq(periph_irq), .gpio_irq(gpio_irq),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .cpu_irq(cpu_irq)
  );

  // reference model built from the requirements
  logic [15:0] ms_lo, ms_hi, mm_lo, mm_hi;
  logic [31:0] mp_st, mp_mk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_lo <= '0; ms_hi <= '0; mm_lo <= '0; mm_hi <= '0;
      mp_st <= '0; mp_mk <= '0;
    end else begin
      automatic logic [15:0] lo = periph_irq[15:0];
      automatic logic [15:0] c_lo = 0, c_hi = 0, c_plo = 0, c_phi = 0;
      lo[9] = |(mp_st & mp_mk);
      if (wr_en) begin
        case (addr)
          9'h080: c_lo = wr_data;
          9'h0A0: c_hi = wr_data;
          9'h088, 9'h108: c_plo = wr_data;
          9'h08A, 9'h10A: c_phi = wr_data;
          9'h08C: mm_lo <= wr_data;
          9'h0A6: mm_hi <= wr_data;
          9'h094: mp_mk[15:0] <= wr_data;
          9'h096: mp_mk[31:16] <= wr_data;
          default: ;
        endcase
      end
      ms_lo <= lo & ~c_lo;
      ms_hi <= {6'b0, periph_irq[25:16]} & ~c_hi;
      mp_st <= gpio_irq & ~{c_phi, c_plo};
    end
  end

  function automatic logic [15:0] exp_rd(logic [8:0] a);
    case (a)
      9'h080: return ms_lo;
      9'h0A0: return ms_hi;
      9'h08C: return mm_lo;
      9'h0A6: return mm_hi;
      9'h088, 9'h108: return mp_st[15:0];
      9'h08A, 9'h10A: return mp_st[31:16];
      9'h094: return mp_mk[15:0];
      9'h096: return mp_mk[31:16];
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return ((ms_lo & mm_lo) != 0) || ((ms_hi & mm_hi) != 0);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [8:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(string tag, logic [8:0] a, logic [15:0] exp);
    addr = a; #0.1;
    chk(tag, rd_data, exp);
  endtask

  task automatic rd_model(string tag, logic [8:0] a);
    addr = a; #0.1;
    chk(tag, rd_data, exp_rd(a));
  endtask

  localparam logic [8:0] ALL [10] = '{9'h080, 9'h08C, 9'h0A0, 9'h0A6, 9'h088,
                                      9'h08A, 9'h108, 9'h10A, 9'h094, 9'h096};
  localparam logic [8:0] PICK [16] = '{9'h080, 9'h08C, 9'h0A0, 9'h0A6, 9'h088,
                                       9'h08A, 9'h108, 9'h10A, 9'h094, 9'h096,
                                       9'h082, 9'h084, 9'h08E, 9'h0A2, 9'h100, 9'h1FE};

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1: reset state
    for (int k = 0; k < 10; k++) rd("R1 reset read", ALL[k], 16'h0);
    chk("R1 cpu_irq after reset", {15'b0, cpu_irq}, 16'h0);

    // R2: low and high words
    @(negedge clk); periph_irq = 26'h1 << 3;
    tick(); rd("R2 line3 to low word", 9'h080, 16'h0008);
    @(negedge clk); periph_irq = (26'h1 << 20) | (26'h1 << 3);
    tick(); rd("R2 line20 to high bit4", 9'h0A0, 16'h0010);
    // R3: deassert clears
    @(negedge clk); periph_irq = 26'h1 << 20;
    tick(); rd("R3 line3 drop clears", 9'h080, 16'h0000);
    @(negedge clk); periph_irq = '0;
    tick(); rd("R3 line20 drop clears", 9'h0A0, 16'h0000);

    // R6: clear with source held re-sets one clock later
    @(negedge clk); periph_irq = 26'h1 << 5;
    tick();
    wr(9'h080, 16'h0020);
    rd("R6 cleared at write", 9'h080, 16'h0000);
    tick(); rd("R6 re-set next clock", 9'h080, 16'h0020);

    // R4/R5: masks
    wr(9'h08C, 16'h0020);
    rd("R5 mask_lo readback", 9'h08C, 16'h0020);
    chk("R4 irq on low word", {15'b0, cpu_irq}, 16'h0001);
    wr(9'h08C, 16'hFFDF);
    rd("R5 mask_lo replaced", 9'h08C, 16'hFFDF);
    chk("R4 irq off when masked", {15'b0, cpu_irq}, 16'h0000);
    @(negedge clk); periph_irq = 26'h1 << 25;
    wr(9'h0A6, 16'h0200);
    rd("R2 line25 to high bit9", 9'h0A0, 16'h0200);
    chk("R4 irq on high word", {15'b0, cpu_irq}, 16'h0001);
    wr(9'h08C, 16'h0000); wr(9'h0A6, 16'h0000);
    @(negedge clk); periph_irq = '0;

    // R2: upper bits of high word stay zero
    wr(9'h0A6, 16'hFC00);
    rd("R2 high word upper zero", 9'h0A0, 16'h0000);
    chk("R4 no irq from empty bits", {15'b0, cpu_irq}, 16'h0000);
    wr(9'h0A6, 16'h0000);

    // R7: pin status words and aliases
    @(negedge clk); gpio_irq = (32'h1 << 17) | (32'h1 << 1);
    tick();
    rd("R7 pin low at 088", 9'h088, 16'h0002);
    rd("R7 pin low at 108", 9'h108, 16'h0002);
    rd("R7 pin high at 08A", 9'h08A, 16'h0002);
    rd("R7 pin high at 10A", 9'h10A, 16'h0002);
    wr(9'h108, 16'h0002);
    rd("R7 pin clear via 108", 9'h088, 16'h0000);
    tick(); rd("R7 pin re-set", 9'h088, 16'h0002);

    // R9: external line 9 ignored, cascade drives bit 9
    @(negedge clk); periph_irq = 26'h1 << 9;
    tick(); tick();
    rd("R9 external line9 ignored", 9'h080, 16'h0000);
    wr(9'h096, 16'h0002);
    rd("R8 pin mask high readback", 9'h096, 16'h0002);
    rd("R9 bit9 not yet set", 9'h080, 16'h0000);
    tick(); rd("R9 cascade sets bit9", 9'h080, 16'h0200);
    wr(9'h08C, 16'h0200);
    chk("R9 cascade reaches cpu_irq", {15'b0, cpu_irq}, 16'h0001);
    wr(9'h094, 16'hABCD);
    rd("R8 pin mask low readback", 9'h094, 16'hABCD);
    @(negedge clk); gpio_irq = '0;
    tick(); tick();
    rd("R9 cascade drops bit9", 9'h080, 16'h0000);

    // R10: unused offsets
    wr(9'h082, 16'hFFFF);
    wr(9'h1FE, 16'hFFFF);
    for (int k = 0; k < 10; k++) rd_model("R10 unused write no effect", ALL[k]);
    rd("R10 unused read 082", 9'h082, 16'h0000);
    rd("R10 unused read 084", 9'h084, 16'h0000);

    // random phase
    for (int it = 0; it < 600; it++) begin
      @(negedge clk);
      periph_irq = 26'($urandom) & 26'($urandom);
      gpio_irq   = $urandom & $urandom;
      wr_en   = ($urandom % 3) == 0;
      addr    = PICK[$urandom % 16];
      wr_data = 16'($urandom);
      @(posedge clk); #1;
      wr_en = 1'b0;
      chk("R4 random cpu_irq", {15'b0, cpu_irq}, {15'b0, exp_irq()});
      rd_model("R2 R6 R7 R9 random read", PICK[$urandom % 16]);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule